// File: doc/BRIEF.md
# Codec immediate-command engine

This block drives one command at a time into a codec link controller's immediate-command register window over a simple memory-mapped master bus, and returns the codec's 32-bit answer. A caller places a command word on the input and pulses `start`. The engine first polls the status register until the controller reports it is no longer busy. It then writes the command and sets the trigger bits in the status register. After a fixed quiet interval it polls for a valid response and finally reads the response register. The result is reported with a one-cycle `done` pulse together with either `ok` or `err`.

All waiting is paced by a one-cycle microsecond tick from outside the block, so the retry budgets and the quiet interval are counted in microseconds whatever the clock frequency. When `use_vid` is set at start, the engine ignores the command input and builds the vendor-ID query for the given codec address itself. Only one command can be in flight, and a start pulse that arrives while a command is in flight is dropped.

Top module: `ccmd_engine`

## Requirements
- R1: While and after reset, `done`, `ok`, `err`, `busy_o`, `bus_req` and `rsp` are all 0.
- R2: A `start` in idle makes the first bus transaction a read of the status register at offset 0x68. A read with bit 0 (busy) set is repeated after exactly one `us_tick` pulse. At most RDY_TRIES (50) such reads are made.
- R3: If all RDY_TRIES status reads show busy, the engine ends with `done`=1, `err`=1, `ok`=0 and `rsp`=0, and issues no write.
- R4: After a status read with bit 0 clear, the engine writes the command word to offset 0x60, and then writes 0x00000003 (valid and busy bits set) to offset 0x68.
- R5: After the trigger write completes, exactly SETTLE_US (25) `us_tick` pulses pass with no bus traffic before the next status read.
- R6: The response poll reads offset 0x68 until bits [1:0] equal 2'b10, waiting one `us_tick` between reads, for at most VAL_TRIES (50) reads. On exhaustion it ends with `err`=1 and `rsp`=0.
- R7: On a valid status, the engine reads offset 0x64 and ends with `done`=1, `ok`=1, and `rsp` equal to the data read.
- R8: With `use_vid`=1 at start, the command written is (`codec_addr` << 28) | 0x000F0000 and `cmd_word` is ignored.
- R9: A `start` while a command is in flight has no effect on the bus transactions or the result, and no bus request is made while `busy_o` is low.
- R10: `done` lasts one cycle, and exactly one of `ok` and `err` is high with it and never without it. `busy_o` is high from the cycle after an accepted start and low in the `done` cycle.
- R11: A bus request stays asserted, with address, direction and write data unchanged, until the cycle in which `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| start | input | 1 | Begin a command (taken only when idle) |
| use_vid | input | 1 | Send the vendor-ID query instead of cmd_word |
| codec_addr | input | 4 | Codec address for the vendor-ID query |
| cmd_word | input | 32 | Command word to send |
| busy_o | output | 1 | A command is in flight |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | With done: response received |
| err | output | 1 | With done: a poll budget ran out |
| rsp | output | 32 | Response word, zero after a timeout |
| bus_req | output | 1 | Bus request, held until acknowledged |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 8 | Register offset |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Completes the current request |

## Verification
The bench goes after the edges of both poll budgets: a controller that clears its busy bit or raises its valid bit only on the 50th read, and one that never does. A design whose limit is off by one either times out on a command that should have succeeded or makes a 51st read. Tick counts between transactions are measured, so a quiet interval one microsecond short or long, or a retry that does not wait for a tick, shows up as a gap mismatch. Status values with the busy and valid bits set together, or with neither set, check that the response poll tests both bits and does not accept on valid alone. A second start injected mid-command checks that a design which re-latches the command or restarts the sequence is caught.

// File: rtl/ccmd_pkg.sv
package ccmd_pkg;
  localparam int unsigned BUS_AW = 8;
  localparam int unsigned WORD_W = 32;

  localparam logic [BUS_AW-1:0] OFS_CMD  = 8'h60;
  localparam logic [BUS_AW-1:0] OFS_RSP  = 8'h64;
  localparam logic [BUS_AW-1:0] OFS_STAT = 8'h68;

  localparam int unsigned BIT_BUSY  = 0;
  localparam int unsigned BIT_VALID = 1;

  localparam logic [WORD_W-1:0] TRIG_WORD = 32'h0000_0003;
  localparam logic [WORD_W-1:0] VID_VERB  = 32'h000F_0000;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RDY_RD, ST_RDY_GAP, ST_CMD_WR, ST_TRIG_WR,
    ST_SETTLE, ST_VAL_RD, ST_VAL_GAP, ST_RSP_RD
  } ccmd_state_e;
endpackage

// File: rtl/ccmd_cnt.sv
module ccmd_cnt #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ccmd_cmd_build.sv
module ccmd_cmd_build
  import ccmd_pkg::*;
#(
  parameter int unsigned CAD_W = 4
) (
  input  logic              use_vid,
  input  logic [CAD_W-1:0]  cad,
  input  logic [WORD_W-1:0] cmd_in,
  output logic [WORD_W-1:0] cmd_out
);
  logic [WORD_W-1:0] vid_q;
  assign vid_q   = {cad, {(WORD_W-CAD_W){1'b0}}} | VID_VERB;
  assign cmd_out = use_vid ? vid_q : cmd_in;
endmodule

// File: rtl/ccmd_engine.sv
module ccmd_engine
  import ccmd_pkg::*;
#(
  parameter int unsigned RDY_TRIES = 50,
  parameter int unsigned VAL_TRIES = 50,
  parameter int unsigned SETTLE_US = 25,
  parameter int unsigned CAD_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              us_tick,
  input  logic              start,
  input  logic              use_vid,
  input  logic [CAD_W-1:0]  codec_addr,
  input  logic [WORD_W-1:0] cmd_word,
  output logic              busy_o,
  output logic              done,
  output logic              ok,
  output logic              err,
  output logic [WORD_W-1:0] rsp,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata,
  input  logic              bus_ack
);
  localparam int unsigned MAX_TRY = (RDY_TRIES > VAL_TRIES) ? RDY_TRIES : VAL_TRIES;
  localparam int unsigned MAX_CNT = (MAX_TRY > SETTLE_US) ? MAX_TRY : SETTLE_US;
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);

  ccmd_state_e       state;
  logic [WORD_W-1:0] cmd_sel, cmd_q;
  logic [CNT_W-1:0]  try_cnt, wait_cnt;
  logic              try_clr, try_inc, wait_clr, wait_inc;
  logic              rdy_last, val_last, settle_end, stat_busy, resp_valid;

  ccmd_cmd_build #(.CAD_W(CAD_W)) u_build (
    .use_vid (use_vid),
    .cad     (codec_addr),
    .cmd_in  (cmd_word),
    .cmd_out (cmd_sel)
  );

  ccmd_cnt #(.W(CNT_W)) u_try (
    .clk(clk), .rst(rst), .clr(try_clr), .inc(try_inc), .cnt(try_cnt)
  );

  ccmd_cnt #(.W(CNT_W)) u_wait (
    .clk(clk), .rst(rst), .clr(wait_clr), .inc(wait_inc), .cnt(wait_cnt)
  );

  assign stat_busy  = bus_rdata[BIT_BUSY];
  assign resp_valid = bus_rdata[BIT_VALID] && !bus_rdata[BIT_BUSY];
  assign rdy_last   = (try_cnt == CNT_W'(RDY_TRIES - 1));
  assign val_last   = (try_cnt == CNT_W'(VAL_TRIES - 1));
  assign settle_end = us_tick && (wait_cnt == CNT_W'(SETTLE_US - 1));

  assign try_clr  = (state == ST_IDLE) || (state == ST_SETTLE);
  assign try_inc  = bus_ack && ((state == ST_RDY_RD) || (state == ST_VAL_RD));
  assign wait_clr = (state != ST_SETTLE);
  assign wait_inc = (state == ST_SETTLE) && us_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cmd_q     <= '0;
      busy_o    <= 1'b0;
      done      <= 1'b0;
      ok        <= 1'b0;
      err       <= 1'b0;
      rsp       <= '0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      done <= 1'b0;
      ok   <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          cmd_q    <= cmd_sel;
          busy_o   <= 1'b1;
          bus_req  <= 1'b1;
          bus_we   <= 1'b0;
          bus_addr <= OFS_STAT;
          state    <= ST_RDY_RD;
        end
        ST_RDY_RD: if (bus_ack) begin
          bus_req <= 1'b0;
          if (!stat_busy) begin
            bus_req   <= 1'b1;
            bus_we    <= 1'b1;
            bus_addr  <= OFS_CMD;
            bus_wdata <= cmd_q;
            state     <= ST_CMD_WR;
          end else if (rdy_last) begin
            state  <= ST_IDLE;
            busy_o <= 1'b0;
            done   <= 1'b1;
            err    <= 1'b1;
            rsp    <= '0;
          end else begin
            state <= ST_RDY_GAP;
          end
        end
        ST_RDY_GAP: if (us_tick) begin
          bus_req  <= 1'b1;
          bus_we   <= 1'b0;
          bus_addr <= OFS_STAT;
          state    <= ST_RDY_RD;
        end
        ST_CMD_WR: if (bus_ack) begin
          bus_addr  <= OFS_STAT;
          bus_wdata <= TRIG_WORD;
          state     <= ST_TRIG_WR;
        end
        ST_TRIG_WR: if (bus_ack) begin
          bus_req <= 1'b0;
          bus_we  <= 1'b0;
          state   <= ST_SETTLE;
        end
        ST_SETTLE: if (settle_end) begin
          bus_req  <= 1'b1;
          bus_addr <= OFS_STAT;
          state    <= ST_VAL_RD;
        end
        ST_VAL_RD: if (bus_ack) begin
          bus_req <= 1'b0;
          if (resp_valid) begin
            bus_req  <= 1'b1;
            bus_addr <= OFS_RSP;
            state    <= ST_RSP_RD;
          end else if (val_last) begin
            state  <= ST_IDLE;
            busy_o <= 1'b0;
            done   <= 1'b1;
            err    <= 1'b1;
            rsp    <= '0;
          end else begin
            state <= ST_VAL_GAP;
          end
        end
        ST_VAL_GAP: if (us_tick) begin
          bus_req  <= 1'b1;
          bus_addr <= OFS_STAT;
          state    <= ST_VAL_RD;
        end
        ST_RSP_RD: if (bus_ack) begin
          bus_req <= 1'b0;
          state   <= ST_IDLE;
          busy_o  <= 1'b0;
          done    <= 1'b1;
          ok      <= 1'b1;
          rsp     <= bus_rdata;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ccmd_engine_chk.sv
module ccmd_engine_chk
  import ccmd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              busy_o,
  input logic              done,
  input logic              ok,
  input logic              err,
  input logic [WORD_W-1:0] rsp,
  input logic              bus_req,
  input logic              bus_we,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic              bus_ack
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    done |-> (ok != err)); // R10

  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !done |-> !ok && !err); // R10

  AST_BUSY_BEFORE_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy_o) && !busy_o); // R10

  AST_ERR_ZERO_RSP: assert property (@(posedge clk) disable iff (rst)
    done && err |-> rsp == '0); // R3

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !bus_req); // R9

  AST_WRITE_TARGET: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_we |-> (bus_addr == OFS_CMD) ||
                          (bus_addr == OFS_STAT && bus_wdata == TRIG_WORD)); // R4
endmodule

bind ccmd_engine ccmd_engine_chk u_chk (.*);

// File: tb/ccmd_engine_bench.sv
module ccmd_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1, us_tick, start = 0, use_vid = 0;
  logic [3:0]  codec_addr = 0;
  logic [31:0] cmd_word = 0, rsp, bus_wdata, bus_rdata;
  logic        busy_o, done, ok, err, bus_req, bus_we, bus_ack;
  logic [7:0]  bus_addr;

  ccmd_engine u_ccmd_engine (
    .clk(clk), .rst(rst), .us_tick(us_tick), .start(start), .use_vid(use_vid),
    .codec_addr(codec_addr), .cmd_word(cmd_word), .busy_o(busy_o), .done(done),
    .ok(ok), .err(err), .rsp(rsp), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;

  task automatic chk(input bit c, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!c) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // microsecond tick: one pulse every 4 clocks
  int tick_div;
  always @(posedge clk) begin
    if (rst) begin tick_div <= 0; us_tick <= 0; end
    else begin
      tick_div <= (tick_div == 3) ? 0 : tick_div + 1;
      us_tick  <= (tick_div == 3);
    end
  end

  // scripted register-window slave
  int busy_n, inval_n, lat, lat_cnt, rd_a, rd_b;
  bit trig_seen;
  logic [31:0] rsp_val;
  always @(posedge clk) begin
    if (rst) begin
      bus_ack <= 0; bus_rdata <= 0; lat_cnt <= 0; trig_seen <= 0; rd_a <= 0; rd_b <= 0;
    end else begin
      if (start && !busy_o) begin trig_seen <= 0; rd_a <= 0; rd_b <= 0; end
      if (bus_ack) begin bus_ack <= 0; lat_cnt <= 0; end
      else if (bus_req) begin
        if (lat_cnt >= lat) begin
          bus_ack <= 1;
          if (bus_we) begin
            if (bus_addr == 8'h68) trig_seen <= 1;
            bus_rdata <= 0;
          end else if (bus_addr == 8'h68) begin
            if (!trig_seen) begin
              bus_rdata <= (rd_a < busy_n) ? ((rd_a % 2) ? 32'h1 : 32'h3) : 32'h2;
              rd_a <= rd_a + 1;
            end else begin
              bus_rdata <= (rd_b < inval_n) ?
                ((rd_b % 3 == 0) ? 32'h3 : (rd_b % 3 == 1) ? 32'h0 : 32'hFFFF_FFFD) : 32'hFFFF_FFFE;
              rd_b <= rd_b + 1;
            end
          end else if (bus_addr == 8'h64) bus_rdata <= rsp_val;
          else bus_rdata <= 32'hDEAD_BEEF;
        end else lat_cnt <= lat_cnt + 1;
      end
    end
  end

  // reference model: expected transactions and outcome
  bit          we_q[$];
  logic [7:0]  addr_q[$];
  logic [31:0] data_q[$];
  int          gap_q[$];
  string       tag_q[$];
  bit exp_busy = 0, exp_ok = 0, done_seen = 0;
  logic [31:0] exp_rsp = 0;
  string done_tag = "R7";
  int tick_cnt = 0, cur_gap = 0;
  bit in_txn = 0;
  logic [7:0] start_addr;

  always @(negedge clk) begin
    if (!rst) begin
      if (bus_req && !in_txn) begin cur_gap = tick_cnt; in_txn = 1; start_addr = bus_addr; end
      if (!bus_req && busy_o && us_tick) tick_cnt++;
      if (bus_req && bus_ack) begin
        if (addr_q.size() == 0) chk(0, "R9 unexpected transaction", {24'h0, bus_addr}, 0);
        else begin
          automatic bit e_we = we_q.pop_front();
          automatic logic [7:0] e_ad = addr_q.pop_front();
          automatic logic [31:0] e_d = data_q.pop_front();
          automatic int e_g = gap_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(bus_we == e_we, {t, " direction"}, {31'h0, bus_we}, {31'h0, e_we});
          chk(bus_addr == e_ad, {t, " address"}, {24'h0, bus_addr}, {24'h0, e_ad});
          chk(bus_addr == start_addr, "R11 address held", {24'h0, bus_addr}, {24'h0, start_addr});
          if (e_we) chk(bus_wdata == e_d, {t, " write data"}, bus_wdata, e_d);
          chk(cur_gap == e_g, {t, " tick gap"}, cur_gap, e_g);
        end
        in_txn = 0;
        tick_cnt = 0;
      end
      if (done) begin
        chk(addr_q.size() == 0, "R10 done early", addr_q.size(), 0);
        chk(exp_busy && !busy_o, "R10 busy at done", {31'h0, busy_o}, 0);
        chk(ok == exp_ok && err == !exp_ok, {done_tag, " outcome"}, {30'h0, ok, err}, {30'h0, exp_ok, !exp_ok});
        chk(rsp == exp_rsp, {done_tag, " response"}, rsp, exp_rsp);
        exp_busy = 0;
        done_seen = 1;
      end else begin
        chk(busy_o == exp_busy, "R10 busy", {31'h0, busy_o}, {31'h0, exp_busy});
        chk(!ok && !err, "R10 flags without done", {30'h0, ok, err}, 0);
      end
    end
  end

  task automatic push(input bit w, input logic [7:0] a, input logic [31:0] d, input int g, input string t);
    we_q.push_back(w); addr_q.push_back(a); data_q.push_back(d); gap_q.push_back(g); tag_q.push_back(t);
  endtask

  task automatic run_case(input int bn, input int vn, input bit uv, input logic [3:0] cad,
                          input logic [31:0] cw, input logic [31:0] rv, input int l, input bit poke);
    automatic bit good = 1;
    automatic logic [31:0] ecmd = uv ? ((32'(cad) << 28) | 32'h000F_0000) : cw;
    automatic int guard = 0;
    busy_n = bn; inval_n = vn; lat = l; rsp_val = rv;
    for (int i = 0; i < ((bn >= 50) ? 50 : bn + 1); i++) push(0, 8'h68, 0, (i == 0) ? 0 : 1, "R2 ready poll");
    if (bn >= 50) begin good = 0; done_tag = "R3"; end
    else begin
      push(1, 8'h60, ecmd, 0, uv ? "R8 query word" : "R4 command write");
      push(1, 8'h68, 32'h3, 0, "R4 trigger write");
      for (int i = 0; i < ((vn >= 50) ? 50 : vn + 1); i++)
        push(0, 8'h68, 0, (i == 0) ? 25 : 1, (i == 0) ? "R5 settle" : "R6 valid poll");
      if (vn >= 50) begin good = 0; done_tag = "R6"; end
      else begin push(0, 8'h64, 0, 0, "R7 response read"); done_tag = "R7"; end
    end
    exp_ok = good; exp_rsp = good ? rv : 32'h0;
    done_seen = 0; tick_cnt = 0;
    @(posedge clk); #2;
    start = 1; use_vid = uv; codec_addr = cad; cmd_word = cw;
    @(posedge clk); #2;
    start = 0; exp_busy = 1;
    if (poke) begin
      repeat (20) @(posedge clk);
      #2 start = 1; use_vid = ~uv; cmd_word = ~cw; codec_addr = ~cad;
      @(posedge clk); #2 start = 0;
    end
    while (!done_seen && guard < 5000) begin @(posedge clk); guard++; end
    chk(done_seen, "R10 done reached", {31'h0, done_seen}, 1);
    repeat (30) @(posedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    chk(!done && !ok && !err && !busy_o && !bus_req && rsp == 0, "R1 reset state",
        {27'h0, done, ok, err, busy_o, bus_req}, 0);
    run_case(0, 0, 0, 4'h0, 32'h1234_5678, 32'hCAFE_F00D, 0, 0);   // R2 R4 R5 R7
    run_case(3, 2, 1, 4'h5, 32'h0BAD_0BAD, 32'h1057_0001, 2, 0);   // R8 R6 retries
    run_case(49, 0, 0, 4'h0, 32'hA5A5_5A5A, 32'h0000_0042, 1, 0);  // R2 last ready try
    run_case(50, 0, 0, 4'h0, 32'h1111_2222, 32'h3333_4444, 0, 0);  // R3 timeout
    run_case(0, 49, 1, 4'hF, 32'h0, 32'h8000_0001, 1, 0);          // R6 last valid try
    run_case(0, 50, 0, 4'h0, 32'h7777_8888, 32'h9999_AAAA, 0, 0);  // R6 timeout
    run_case(2, 1, 0, 4'h3, 32'h0F0F_0F0F, 32'h5555_AAAA, 1, 1);   // R9 start ignored
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule